// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tracking

This block is the receive queue of a serial receiver. It stores up to 64 characters, and each character carries its own three error flags: parity, framing and break. The bit receiver pushes a character and its flags. The host pops the oldest character with a read strobe.

The status outputs always describe the character at the head of the queue: its data and its three flags. A separate summary flag stays high while any stored character, at any position, carries an error. This lets the host learn that a bad character is waiting before it reaches the head.

The block also gives the fill level for an external trigger comparator, plus empty and full flags. A sticky overrun flag records characters lost because the queue was full. A synchronous flush input empties the queue and clears every flag.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0, `overrun`=0, `any_err`=0, and the head data and head flags are all zero.
- R2: Characters leave in the order they were accepted. `head_data` shows the oldest stored character, and each pop exposes the next one in the cycle after the pop.
- R3: `level` equals the number of stored characters (0..64). `empty` is high exactly at level 0 and `full` is high exactly at level 64. Both update one cycle after the push or pop.
- R4: `head_par_err`, `head_frm_err` and `head_brk` show the parity, framing and break flags that were pushed with the current head character.
- R5: While the queue is empty, `head_data` and all three head flags read zero.
- R6: `any_err` is high one cycle after any stored character has at least one flag set. It stays high until the last such character has been popped, whatever its position.
- R7: A push while `full` is high discards the incoming character. Level and contents are unchanged, and `overrun` becomes 1 in the next cycle.
- R8: `overrun` stays set until a cycle with `stat_rd` high, and clears after it. If a discarded push and `stat_rd` occur in the same cycle, the flag ends up set.
- R9: A push and a pop in the same cycle on a non-empty, non-full queue leave `level` unchanged. The error summary accounts for both the new and the removed character.
- R10: A pop while `empty` is high is ignored. Nothing changes and nothing underflows.
- R11: A cycle with `flush` high empties the queue and clears `overrun` and `any_err`. A push or pop in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | 8 | Character to push |
| wr_par_err | input | 1 | Parity error flag of the pushed character |
| wr_frm_err | input | 1 | Framing error flag of the pushed character |
| wr_brk | input | 1 | Break flag of the pushed character |
| rd_en | input | 1 | Pop strobe from the host |
| stat_rd | input | 1 | Status read; clears overrun |
| head_data | output | 8 | Character at the head of the queue |
| head_par_err | output | 1 | Parity flag of the head character |
| head_frm_err | output | 1 | Framing flag of the head character |
| head_brk | output | 1 | Break flag of the head character |
| any_err | output | 1 | Some stored character carries an error |
| empty | output | 1 | Queue holds nothing |
| full | output | 1 | Queue holds 64 characters |
| level | output | 7 | Number of stored characters |
| overrun | output | 1 | Sticky: a character was discarded |

## Verification
Directed phases first push clean characters, then characters with each single flag, and pop them. This separates the head-following flags from the summary flag. An errored character is buried behind clean ones and then drained, which shows that the summary holds for errors away from the head and drops only after the last one leaves. Filling to 64 and pushing more, with and without a status read in the same cycle, separates discarding from storing and the set-over-clear rule. A long random mix of pushes, pops, status reads and flushes then exercises wrap-around, simultaneous push and pop, and pops from an empty queue.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxerr_t;
  localparam int ERR_W = $bits(rxerr_t);
endpackage

// File: rtl/rx_err_fifo_mem.sv
module rx_err_fifo_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rx_err_fifo_ctrl.sv
module rx_err_fifo_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          stat_rd,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overrun
);
  logic [LW-1:0] lvl_nx;

  assign push_ok = wr_en && !full  && !flush;
  assign pop_ok  = rd_en && !empty && !flush;
  assign lvl_nx  = level + LW'(push_ok) - LW'(pop_ok);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      empty   <= 1'b1;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_ok);
      rd_ptr <= rd_ptr + AW'(pop_ok);
      level  <= lvl_nx;
      empty  <= (lvl_nx == '0);
      full   <= (lvl_nx == LW'(DEPTH));
      if (wr_en && full) overrun <= 1'b1;
      else if (stat_rd)  overrun <= 1'b0;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !rd_en && !flush |=> full && $stable(level));
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !flush |=> overrun);
  p_pushpop_level_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_en && !empty && !full && !flush |=> $stable(level));
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && empty && !flush |=> empty && $stable(rd_ptr));
  p_flush_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty && !overrun && level == '0);
endmodule

// File: rtl/rx_err_fifo_errcnt.sv
module rx_err_fifo_errcnt #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_ok,
  input  logic          push_err,
  input  logic          pop_ok,
  input  logic          head_err,
  input  logic [LW-1:0] level,
  input  logic          empty,
  output logic          any_err
);
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + LW'(push_ok && push_err) - LW'(pop_ok && head_err);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q   <= '0;
      any_err <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      any_err <= (cnt_nx != '0);
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= level);
  p_err_empty_r6: assert property (@(posedge clk) disable iff (rst)
    empty |-> !any_err);
  p_err_push_r6: assert property (@(posedge clk) disable iff (rst)
    push_ok && push_err |=> any_err);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int EW = rx_err_fifo_pkg::ERR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par_err,
  input  logic              wr_frm_err,
  input  logic              wr_brk,
  input  logic              rd_en,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] head_data,
  output logic              head_par_err,
  output logic              head_frm_err,
  output logic              head_brk,
  output logic              any_err,
  output logic              empty,
  output logic              full,
  output logic [LW-1:0]     level,
  output logic              overrun
);
  import rx_err_fifo_pkg::*;

  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  rxerr_t        in_err, hd_err;
  logic [EW-1:0] raw;

  assign in_err = '{brk: wr_brk, frm: wr_frm_err, par: wr_par_err};
  assign hd_err = raw[EW-1:DATA_W];

  rx_err_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .stat_rd(stat_rd), .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .empty(empty),
    .full(full), .overrun(overrun)
  );

  rx_err_fifo_mem #(.DEPTH(DEPTH), .WIDTH(EW)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata({in_err, wr_data}),
    .raddr(rd_ptr), .rdata(raw)
  );

  rx_err_fifo_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst(rst), .flush(flush), .push_ok(push_ok),
    .push_err(|in_err), .pop_ok(pop_ok), .head_err(|hd_err),
    .level(level), .empty(empty), .any_err(any_err)
  );

  assign head_data    = empty ? '0   : raw[DATA_W-1:0];
  assign head_par_err = empty ? 1'b0 : hd_err.par;
  assign head_frm_err = empty ? 1'b0 : hd_err.frm;
  assign head_brk     = empty ? 1'b0 : hd_err.brk;

  p_empty_head_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> head_data == '0 && !head_par_err && !head_frm_err && !head_brk);
  p_head_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (head_par_err || head_frm_err || head_brk) |-> any_err);
endmodule

// File: tb/rx_err_fifo_bench.sv
module rx_err_fifo_bench;
  logic clk = 1'b0;
  logic rst, flush, wr_en, rd_en, stat_rd, wr_par_err, wr_frm_err, wr_brk;
  logic [7:0] wr_data;
  logic [7:0] head_data;
  logic head_par_err, head_frm_err, head_brk, any_err, empty, full, overrun;
  logic [6:0] level;

  int checks = 0, failures = 0;
  logic [10:0] q[$];
  bit m_ovr;

  always #5 clk = ~clk;

  rx_err_fifo u_rx_err_fifo (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_brk(wr_brk),
    .rd_en(rd_en), .stat_rd(stat_rd), .head_data(head_data),
    .head_par_err(head_par_err), .head_frm_err(head_frm_err),
    .head_brk(head_brk), .any_err(any_err), .empty(empty), .full(full),
    .level(level), .overrun(overrun)
  );

  // Reference model: entry = {brk, frm, par, data}
  always @(posedge clk) begin
    if (rst || flush) begin
      q.delete();
      m_ovr = 1'b0;
    end else begin
      automatic int sz = q.size();
      if (rd_en && sz > 0) void'(q.pop_front());
      if (wr_en && sz < 64) q.push_back({wr_brk, wr_frm_err, wr_par_err, wr_data});
      if (wr_en && sz == 64) m_ovr = 1'b1;
      else if (stat_rd) m_ovr = 1'b0;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    automatic bit e_err = 0;
    automatic logic [10:0] h = (q.size() > 0) ? q[0] : 11'd0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) e_err = 1;
    chk("R3", "level", int'(level), q.size());
    chk("R3", "empty", int'(empty), int'(q.size() == 0));
    chk("R3", "full", int'(full), int'(q.size() == 64));
    chk("R2", "head_data", int'(head_data), int'(h[7:0]));
    chk("R4", "head_par", int'(head_par_err), int'(h[8]));
    chk("R4", "head_frm", int'(head_frm_err), int'(h[9]));
    chk("R4", "head_brk", int'(head_brk), int'(h[10]));
    chk("R6", "any_err", int'(any_err), int'(e_err));
    chk("R8", "overrun", int'(overrun), int'(m_ovr));
  endtask

  // one cycle: drive at negedge, then compare after the next edge
  task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] fl,
                     input bit r, input bit s, input bit f);
    wr_en = w; wr_data = d; {wr_brk, wr_frm_err, wr_par_err} = fl;
    rd_en = r; stat_rd = s; flush = f;
    @(negedge clk);
    compare_all();
  endtask

  bit done = 0;
  initial begin
    #1500000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; flush = 0; wr_en = 0; rd_en = 0; stat_rd = 0;
    wr_data = 0; wr_par_err = 0; wr_frm_err = 0; wr_brk = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state, R5 empty head zero
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "level", int'(level), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "any_err", int'(any_err), 0);
    chk("R5", "head", int'({head_data, head_par_err, head_frm_err, head_brk}), 0);
    // R10 pop on empty
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10", "empty after empty pop", int'(empty), 1);
    // R2 clean pushes
    for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 3'b000, 0, 0, 0);
    // R4 each flag alone, buried behind clean data
    cyc(1, 8'hA1, 3'b001, 0, 0, 0);
    cyc(1, 8'hA2, 3'b010, 0, 0, 0);
    cyc(1, 8'hA3, 3'b100, 0, 0, 0);
    cyc(1, 8'h20, 3'b000, 0, 0, 0);
    chk("R6", "any_err with buried error", int'(any_err), 1);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1, 0, 0);
    chk("R6", "any_err drained", int'(any_err), 0);
    chk("R5", "head after drain", int'(head_data), 0);
    // R7 fill and overflow
    for (int i = 0; i < 64; i++) cyc(1, 8'(i), (i == 63) ? 3'b010 : 3'b000, 0, 0, 0);
    chk("R3", "full at 64", int'(full), 1);
    cyc(1, 8'hEE, 3'b111, 0, 0, 0);
    chk("R7", "overrun set", int'(overrun), 1);
    chk("R7", "level held", int'(level), 64);
    // R8 clear then coincident set/clear
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8", "overrun cleared", int'(overrun), 0);
    cyc(1, 8'hEF, 3'b000, 0, 1, 0);
    chk("R8", "set wins", int'(overrun), 1);
    // R9 simultaneous push/pop
    cyc(0, 0, 0, 1, 1, 0);
    cyc(1, 8'h55, 3'b001, 1, 0, 0);
    chk("R9", "level stable", int'(level), 63);
    // R11 flush with push/pop
    cyc(1, 8'h77, 3'b100, 1, 0, 1);
    chk("R11", "flushed empty", int'(empty), 1);
    chk("R11", "flushed any_err", int'(any_err), 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      automatic int k = $urandom_range(0, 99);
      cyc(k < 60, 8'($urandom), 3'($urandom_range(0, 7)) & ((k % 3 == 0) ? 3'b111 : 3'b000),
          (k % 4 == 1) || (k > 80 && i > 2000), k % 11 == 0, k == 99);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule